// File: doc/BRIEF.md
# Condition and Fixed-Point Status Register File

This block holds two architectural status registers. The first is a 32-bit condition word made of eight 4-bit fields. Each field carries a less-than, a greater-than, an equal and a summary-overflow flag. The second is a fixed-point exception word with sticky summary-overflow, overflow and carry flags and a 7-bit byte count for string transfers.

Both words are readable combinationally, and each can be written whole through a special-register move port. The condition word also has an absolute-bit read port and an absolute-bit write port. A compare-update port writes one condition field in a single cycle. The update comes either from a signed test of a 64-bit result against zero or from an unsigned compare of two 64-bit operands, and its fourth bit is taken from the exception word's summary-overflow flag.

All writes that arrive in one cycle take effect together at the next clock edge. The layering is fixed: a full-word write is applied first, a single-bit write is applied over it, and a compare-update is applied over both for its field.

Top module: `cond_status_regs`

## Requirements
- R1: After reset, `cr_rdata` and `xr_rdata` both read 0 and `bit_rd_val` reads 0 for every index.
- R2: A full-word condition write appears on `cr_rdata` from the next cycle. Field f occupies bits [31-4f:28-4f], so field 0 is the top nibble. Inside a field, less-than has weight 8, greater-than 4, equal 2 and summary-overflow 1.
- R3: `bit_rd_val` returns bit 31-n of the condition word for absolute index n. Index n selects field n/4, and n%4 selects less-than, greater-than, equal and summary-overflow in the order 0, 1, 2, 3.
- R4: A single-bit write to index n changes only word bit 31-n at the next edge. Every other bit keeps its value.
- R5: A signed compare-update (`cmp_unsigned`=0) sets exactly one of less-than (`cmp_a` negative), equal (`cmp_a` zero) or greater-than (`cmp_a` positive) in field `cmp_field`. `cmp_b` is ignored in this mode.
- R6: An unsigned compare-update (`cmp_unsigned`=1) sets exactly one of less-than, greater-than or equal in field `cmp_field`, from `cmp_a` against `cmp_b` taken as unsigned numbers.
- R7: A compare-update loads the field's summary-overflow bit from exception-word bit 31 as it stood before the edge. An exception-word write in the same cycle does not affect it.
- R8: An exception-word write keeps bits 31 (summary-overflow), 30 (overflow), 29 (carry) and 6:0 (byte count). Bits 28:7 are discarded and always read 0.
- R9: When a compare-update and a single-bit write hit the same field in one cycle, the compare-update result wins for that field. A single-bit write to a different field in the same cycle still takes effect.
- R10: A single-bit write or a compare-update in the same cycle as a full-word condition write overrides the written word at the bits it touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_we | input | 1 | Full-word condition write enable |
| cr_wdata | input | 32 | Full-word condition write data |
| cr_rdata | output | 32 | Condition word |
| xr_we | input | 1 | Exception-word write enable |
| xr_wdata | input | 32 | Exception-word write data |
| xr_rdata | output | 32 | Exception word |
| bit_we | input | 1 | Single-bit write enable |
| bit_wr_idx | input | 5 | Absolute bit index for the write |
| bit_wr_val | input | 1 | Bit value to write |
| bit_rd_idx | input | 5 | Absolute bit index for the read |
| bit_rd_val | output | 1 | Selected condition bit |
| cmp_en | input | 1 | Compare-update enable |
| cmp_unsigned | input | 1 | 0 = signed test of `cmp_a`, 1 = unsigned compare of `cmp_a` and `cmp_b` |
| cmp_field | input | 3 | Field index to update |
| cmp_a | input | 64 | First operand or result |
| cmp_b | input | 64 | Second operand (unsigned mode) |

## Verification
The bench builds the block with its default parameters: eight fields, 64-bit operands and a 7-bit byte count. At these values the most negative 64-bit value, an all-ones unsigned operand and every field position from top nibble to bottom nibble are all reachable. It drives same-cycle collisions of full-word, single-bit and compare writes, including a compare paired with an exception write that clears summary-overflow. These collisions show the write layering and the sampling of the old summary-overflow value.

// File: rtl/cfx_pkg.sv
package cfx_pkg;

    localparam int FIELD_W = 4;

    // one condition field, most significant bit first
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cfield_t;

    typedef enum logic {
        CMP_SIGNED   = 1'b0,
        CMP_UNSIGNED = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/cfx_compare.sv
module cfx_compare
    import cfx_pkg::*;
#(
    parameter int OPND_W = 64
) (
    input  cmp_mode_e         mode,
    input  logic [OPND_W-1:0] opa,
    input  logic [OPND_W-1:0] opb,
    input  logic              so_in,
    output cfield_t           nib
);

    logic neg_a;
    logic zero_a;

    always_comb begin
        neg_a  = opa[OPND_W-1];
        zero_a = (opa == '0);
        nib.so = so_in;
        if (mode == CMP_SIGNED) begin
            nib.lt = neg_a;
            nib.eq = zero_a;
            nib.gt = !neg_a && !zero_a;
        end else begin
            nib.lt = (opa < opb);
            nib.eq = (opa == opb);
            nib.gt = (opa > opb);
        end
    end

endmodule

// File: rtl/cfx_cond_bank.sv
module cfx_cond_bank
    import cfx_pkg::*;
#(
    parameter  int NUM_FIELDS = 8,
    localparam int WORD_W     = FIELD_W * NUM_FIELDS,
    localparam int BIT_IDX_W  = $clog2(WORD_W),
    localparam int FLD_IDX_W  = $clog2(NUM_FIELDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_we,
    input  logic [WORD_W-1:0]    word_wd,
    input  logic                 bit_we,
    input  logic [BIT_IDX_W-1:0] bit_wr_idx,
    input  logic                 bit_wr_val,
    input  logic                 upd_en,
    input  logic [FLD_IDX_W-1:0] upd_fld,
    input  cfield_t              upd_nib,
    input  logic [BIT_IDX_W-1:0] bit_rd_idx,
    output logic                 bit_rd_val,
    output logic [WORD_W-1:0]    word_q
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } bank_t;

    bank_t st_d, st_q;

    // absolute bit n lives at word position WORD_W-1-n
    logic [BIT_IDX_W-1:0] wr_pos;
    logic [BIT_IDX_W-1:0] rd_pos;

    assign wr_pos = BIT_IDX_W'(WORD_W - 1) - bit_wr_idx;
    assign rd_pos = BIT_IDX_W'(WORD_W - 1) - bit_rd_idx;

    always_comb begin
        st_d = st_q;
        if (word_we) begin
            st_d.word = word_wd;
        end
        if (bit_we) begin
            st_d.word[wr_pos] = bit_wr_val;
        end
        if (upd_en) begin
            for (int f = 0; f < NUM_FIELDS; f++) begin
                if (upd_fld == FLD_IDX_W'(f)) begin
                    st_d.word[WORD_W-1-FIELD_W*f -: FIELD_W] = upd_nib;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q     = st_q.word;
    assign bit_rd_val = st_q.word[rd_pos];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fchk
        localparam int HI = WORD_W - 1 - FIELD_W * g;

        // R5
        cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && upd_fld == FLD_IDX_W'(g)) |=> $countones(word_q[HI -: 3]) == 1);

        // R9
        cmp_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && upd_fld == FLD_IDX_W'(g) && bit_we &&
             bit_wr_idx[BIT_IDX_W-1:2] == FLD_IDX_W'(g))
            |=> word_q[HI -: FIELD_W] == $past(upd_nib));

        // R4
        field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!word_we && !(upd_en && upd_fld == FLD_IDX_W'(g)) &&
             !(bit_we && bit_wr_idx[BIT_IDX_W-1:2] == FLD_IDX_W'(g)))
            |=> $stable(word_q[HI -: FIELD_W]));
    end

endmodule

// File: rtl/cfx_except_reg.sv
module cfx_except_reg #(
    parameter int CNT_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic        so_q,
    output logic [31:0] rd_data
);

    localparam int GAP_W = 29 - CNT_W;

    typedef struct packed {
        logic             so;
        logic             ov;
        logic             ca;
        logic [CNT_W-1:0] cnt;
    } xr_t;

    xr_t st_d, st_q;
    logic unused_mid;

    assign unused_mid = ^wr_data[28:CNT_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.so  = wr_data[31];
            st_d.ov  = wr_data[30];
            st_d.ca  = wr_data[29];
            st_d.cnt = wr_data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign so_q    = st_q.so;
    assign rd_data = {st_q.so, st_q.ov, st_q.ca, {GAP_W{1'b0}}, st_q.cnt};

    // R8
    xr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {$past(wr_data[31:29]), {GAP_W{1'b0}}, $past(wr_data[CNT_W-1:0])});

    // R8
    xr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/cond_status_regs.sv
module cond_status_regs
    import cfx_pkg::*;
#(
    parameter  int NUM_FIELDS = 8,
    parameter  int OPND_W     = 64,
    parameter  int CNT_W      = 7,
    localparam int CR_W       = FIELD_W * NUM_FIELDS,
    localparam int BIT_IDX_W  = $clog2(CR_W),
    localparam int FLD_IDX_W  = $clog2(NUM_FIELDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cr_we,
    input  logic [CR_W-1:0]      cr_wdata,
    output logic [CR_W-1:0]      cr_rdata,
    input  logic                 xr_we,
    input  logic [31:0]          xr_wdata,
    output logic [31:0]          xr_rdata,
    input  logic                 bit_we,
    input  logic [BIT_IDX_W-1:0] bit_wr_idx,
    input  logic                 bit_wr_val,
    input  logic [BIT_IDX_W-1:0] bit_rd_idx,
    output logic                 bit_rd_val,
    input  logic                 cmp_en,
    input  logic                 cmp_unsigned,
    input  logic [FLD_IDX_W-1:0] cmp_field,
    input  logic [OPND_W-1:0]    cmp_a,
    input  logic [OPND_W-1:0]    cmp_b
);

    logic    so_cur;
    cfield_t upd_nib;

    cfx_compare #(.OPND_W(OPND_W)) u_cmp (
        .mode  (cmp_mode_e'(cmp_unsigned)),
        .opa   (cmp_a),
        .opb   (cmp_b),
        .so_in (so_cur),
        .nib   (upd_nib)
    );

    cfx_cond_bank #(.NUM_FIELDS(NUM_FIELDS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (cr_we),
        .word_wd    (cr_wdata),
        .bit_we     (bit_we),
        .bit_wr_idx (bit_wr_idx),
        .bit_wr_val (bit_wr_val),
        .upd_en     (cmp_en),
        .upd_fld    (cmp_field),
        .upd_nib    (upd_nib),
        .bit_rd_idx (bit_rd_idx),
        .bit_rd_val (bit_rd_val),
        .word_q     (cr_rdata)
    );

    cfx_except_reg #(.CNT_W(CNT_W)) u_xr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (xr_we),
        .wr_data (xr_wdata),
        .so_q    (so_cur),
        .rd_data (xr_rdata)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_sochk
        // R7
        so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_en && cmp_field == FLD_IDX_W'(g))
            |=> cr_rdata[CR_W - FIELD_W - FIELD_W*g] == $past(xr_rdata[31]));
    end

endmodule

// File: tb/sim_cond_status_regs.sv
module sim_cond_status_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cr_we, xr_we, bit_we, bit_wr_val, cmp_en, cmp_unsigned;
    logic [31:0] cr_wdata, xr_wdata, cr_rdata, xr_rdata;
    logic [4:0]  bit_wr_idx, bit_rd_idx;
    logic        bit_rd_val;
    logic [2:0]  cmp_field;
    logic [63:0] cmp_a, cmp_b;

    always #5 clk = ~clk;

    cond_status_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
        .xr_we(xr_we), .xr_wdata(xr_wdata), .xr_rdata(xr_rdata),
        .bit_we(bit_we), .bit_wr_idx(bit_wr_idx), .bit_wr_val(bit_wr_val),
        .bit_rd_idx(bit_rd_idx), .bit_rd_val(bit_rd_val),
        .cmp_en(cmp_en), .cmp_unsigned(cmp_unsigned), .cmp_field(cmp_field),
        .cmp_a(cmp_a), .cmp_b(cmp_b)
    );

    typedef struct {
        logic [31:0] cr;
        logic [31:0] xr;
        logic        rbit;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          total = 0;
    int          bad = 0;
    logic [31:0] m_cr = '0;
    logic [31:0] m_xr = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cr_we = 0; xr_we = 0; bit_we = 0; cmp_en = 0;
        cr_wdata = '0; xr_wdata = '0; bit_wr_idx = '0; bit_wr_val = 0;
        cmp_unsigned = 0; cmp_field = '0; cmp_a = '0; cmp_b = '0;
    endtask

    // driver: model the next state from the requirements, queue it
    task automatic issue(input string tag);
        item_t       it;
        logic [31:0] c, x;
        logic        lt, gt, eq;
        c = m_cr;
        x = m_xr;
        if (cr_we) c = cr_wdata;
        if (bit_we) c[31 - int'(bit_wr_idx)] = bit_wr_val;
        if (cmp_en) begin
            if (!cmp_unsigned) begin
                lt = $signed(cmp_a) < 0;
                eq = cmp_a == 0;
                gt = $signed(cmp_a) > 0;
            end else begin
                lt = cmp_a < cmp_b;
                eq = cmp_a == cmp_b;
                gt = cmp_a > cmp_b;
            end
            c[31 - 4*int'(cmp_field) -: 4] = {lt, gt, eq, m_xr[31]};
        end
        if (xr_we) x = xr_wdata & 32'hE000_007F;
        m_cr = c;
        m_xr = x;
        it.cr = c;
        it.xr = x;
        it.rbit = c[31 - int'(bit_rd_idx)];
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        idle();
    endtask

    // monitor: compare after each edge that has an expected item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " cr"}, cr_rdata, it.cr);
                check({it.tag, " xr"}, xr_rdata, it.xr);
                check({it.tag, " R3 bit"}, {31'b0, bit_rd_val}, {31'b0, it.rbit});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        bit_rd_idx = 5'd0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 cr", cr_rdata, 32'h0);
        check("R1 xr", xr_rdata, 32'h0);
        check("R1 bit", {31'b0, bit_rd_val}, 32'h0);

        // R2 layout
        cr_we = 1; cr_wdata = 32'h8421_1248; bit_rd_idx = 5'd0; issue("R2 word write");
        bit_rd_idx = 5'd5;  issue("R3 read idx5");
        bit_rd_idx = 5'd31; issue("R3 read idx31");
        bit_rd_idx = 5'd26; issue("R3 read idx26");

        // R4 single-bit writes
        bit_we = 1; bit_wr_idx = 5'd13; bit_wr_val = 1; bit_rd_idx = 5'd13; issue("R4 set idx13");
        bit_we = 1; bit_wr_idx = 5'd0;  bit_wr_val = 0; bit_rd_idx = 5'd0;  issue("R4 clr idx0");

        // R8 exception word
        xr_we = 1; xr_wdata = 32'hFFFF_FFFF; issue("R8 all ones");
        xr_we = 1; xr_wdata = 32'h5A5A_5AA5; issue("R8 pattern");

        // R5 signed
        cmp_en = 1; cmp_field = 3'd3; cmp_a = -64'sd5; cmp_b = 64'd9; issue("R5 negative");
        cmp_en = 1; cmp_field = 3'd0; cmp_a = 64'd0; cmp_b = 64'd1; issue("R5 zero");
        cmp_en = 1; cmp_field = 3'd7; cmp_a = 64'd7; issue("R5 positive");
        cmp_en = 1; cmp_field = 3'd6; cmp_a = 64'h8000_0000_0000_0000; issue("R5 min");

        // R6 unsigned
        cmp_en = 1; cmp_unsigned = 1; cmp_field = 3'd2; cmp_a = 64'd1; cmp_b = '1; issue("R6 less");
        cmp_en = 1; cmp_unsigned = 1; cmp_field = 3'd2; cmp_a = '1; cmp_b = 64'd1; issue("R6 greater");
        cmp_en = 1; cmp_unsigned = 1; cmp_field = 3'd5; cmp_a = 64'h1234; cmp_b = 64'h1234; issue("R6 equal");

        // R7 summary-overflow copy, old value sampled
        xr_we = 1; xr_wdata = 32'h8000_0003; issue("R7 set so");
        cmp_en = 1; cmp_field = 3'd1; cmp_a = 64'd3; xr_we = 1; xr_wdata = 32'h0; issue("R7 old so");
        cmp_en = 1; cmp_field = 3'd1; cmp_a = 64'd3; issue("R7 so now clear");

        // R9 priority
        cmp_en = 1; cmp_field = 3'd4; cmp_a = 64'd0;
        bit_we = 1; bit_wr_idx = 5'd17; bit_wr_val = 1; bit_rd_idx = 5'd17; issue("R9 same field");
        cmp_en = 1; cmp_field = 3'd1; cmp_a = -64'sd1;
        bit_we = 1; bit_wr_idx = 5'd30; bit_wr_val = 1; bit_rd_idx = 5'd30; issue("R9 other field");

        // R10 override of full-word write
        cr_we = 1; cr_wdata = 32'h0000_0000;
        bit_we = 1; bit_wr_idx = 5'd31; bit_wr_val = 1;
        cmp_en = 1; cmp_field = 3'd0; cmp_a = 64'd2; bit_rd_idx = 5'd31; issue("R10 layered");
        cr_we = 1; cr_wdata = 32'hFFFF_FFFF;
        bit_we = 1; bit_wr_idx = 5'd8; bit_wr_val = 0; bit_rd_idx = 5'd8; issue("R10 bit over word");

        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule